// File: doc/BRIEF.md
# Physical Region Page List Walker

This block turns the two page pointers and the byte count of a storage command into an ordered stream of (address, length) data segments. A downstream data mover consumes the segments. The walker does not move payload bytes. When the transfer spans more than two pages, the second pointer names a list page. The walker reads that list one 64-bit entry at a time through a single-outstanding memory read port. When the last slot of a list page is reached and more than one page of data still remains, that slot is followed to the next list page.

Every pointer is checked before it is used. A zero pointer is rejected, and so is a misaligned data pointer from a list. A transfer whose first pointer lands inside the controller memory buffer window must stay entirely inside that window. After the last segment, or after the first error, the walker raises a one-cycle done pulse. The pulse carries a 16-bit completion status and a flag that marks transfers aimed at the buffer window.

Top module: `prp_walker`

## Requirements
- R1: The first segment has address `prp1`. Its length is the page size minus (`prp1` modulo the page size), capped at `xfer_len`.
- R2: A zero `prp1` ends the walk with status 0x4002 and no segments. In every status word, bits 7:0 hold the code and bit 14 is the do-not-retry flag.
- R3: If bytes remain after the first segment and `prp2` is zero, the walk ends with status 0x4002 and no segments.
- R4: If 1 to page-size bytes remain after the first segment, `prp2` is used as a data pointer. It yields one segment covering all remaining bytes. If it is not page aligned, the walk ends with 0x4002 and no segments.
- R5: If more than one page remains, `prp2` is the base of a list page. Entry i is read at base + 8*i as one 64-bit word, with address bits in the word's natural order. Each entry yields a segment of min(remaining, page size) bytes. Reading stops when the remaining count reaches zero.
- R6: At list index ENTS-1, while more than one page remains, the entry is taken as the next list page, and reading restarts at index 0 of that page.
- R7: A list entry or chain pointer that is zero or not page aligned ends the walk with 0x4002. Segments already issued stand, and no further segment follows.
- R8: An address lies in the buffer window only when `cmb_en` is 1 and `cmb_base` <= addr < `cmb_base` + `cmb_size`. `cmb_flag` at done is 1 exactly when `prp1` is non-zero and lies in the window.
- R9: When `prp1` is in the window, the walk ends with status 0x4012 if any of these lie outside the window: `sq_base`; `prp2` (when bytes remain after the first segment); any list entry that is read.
- R10: A successful walk ends with a single-cycle `done` carrying status 0x0000, one cycle after the last segment is accepted.
- R11: A presented segment or memory request keeps its address and length until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| prp1 | input | ADDR_W | First page pointer |
| prp2 | input | ADDR_W | Second pointer: data page or list page |
| xfer_len | input | LEN_W | Transfer length in bytes |
| sq_base | input | ADDR_W | Base address of the issuing submission queue |
| cmb_en | input | 1 | Buffer window enabled |
| cmb_base | input | ADDR_W | Buffer window base |
| cmb_size | input | ADDR_W | Buffer window size in bytes |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | List entry read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the list entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | List entry value |
| seg_valid | output | 1 | Segment presented |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| done | output | 1 | One-cycle end-of-walk pulse |
| status | output | 16 | Completion status, valid with done |
| cmb_flag | output | 1 | Transfer targets the buffer window, valid with done |

## Verification
The walker is driven with transfers that fit in one page, that need a direct second page, that need a single list page, and that chain through several list pages. The first-page offset is random, so these cases separate the first-segment length arithmetic from the list-walk arithmetic. Corrupted list words are placed at random positions, including chain slots, so the early-stop behaviour is checked both before and after a chain hop. Buffer windows are chosen to contain some pointers and exclude others, and to place a pointer exactly on the window base and on its end. This separates the window decode from the enable bit and from the all-or-nothing rule.

// File: rtl/prp_walk_pkg.sv
// Shared constants and types for the page-pointer list walker.
// Assumes a 16-bit completion status: code in bits 7:0 and do-not-retry flag in bit 14.
package prp_walk_pkg;

    localparam logic [7:0] SC_SUCCESS       = 8'h00;
    localparam logic [7:0] SC_INVALID_FIELD = 8'h02;
    localparam logic [7:0] SC_CMB_MISUSE    = 8'h12;
    localparam int         DNR_BIT          = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SEG,
        ST_REQ,
        ST_RSP,
        ST_DONE
    } walk_state_e;

    // Build an error status word with the do-not-retry flag set
    function automatic logic [15:0] err_status(input logic [7:0] code);
        logic [15:0] s;
        s          = '0;
        s[7:0]     = code;
        s[DNR_BIT] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/prp_win_check.sv
// Buffer window decode: reports whether an address falls in [base, base+size)
// while the window is enabled. The upper bound is tested as an offset from
// the base, so base+size never has to be formed and cannot wrap.
module prp_win_check #(
    parameter int ADDR_W = 64
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    // Window membership
    always_comb hit = en && (addr >= base) && ((addr - base) < size);

endmodule

// File: rtl/prp_ptr_check.sv
// Pointer sanity check: flags zero pointers and pointers that are not on a
// page boundary. The page size is 2**PAGE_BITS bytes.
module prp_ptr_check #(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_zero,
    output logic              misaligned
);

    // Zero and offset-bits tests
    always_comb begin
        is_zero    = (addr == '0);
        misaligned = |addr[PAGE_BITS-1:0];
    end

endmodule

// File: rtl/prp_walker.sv
// Page-pointer list walker. It converts two page pointers and a byte count
// into (address, length) segments, and fetches list pages one 64-bit entry
// per read. It follows a chain through the last slot of each list page.
// Buffer window rules are enforced on every pointer it uses.
// Assumes one read outstanding at a time and that the response arrives no
// earlier than the cycle after the request is accepted.
// Inputs are captured at start, so they may change during a walk.
module prp_walker
    import prp_walk_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int LEN_W     = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENT_BITS  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] prp1,
    input  logic [ADDR_W-1:0] prp2,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [ADDR_W-1:0] sq_base,
    input  logic              cmb_en,
    input  logic [ADDR_W-1:0] cmb_base,
    input  logic [ADDR_W-1:0] cmb_size,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              done,
    output logic [15:0]       status,
    output logic              cmb_flag
);

    localparam logic [LEN_W-1:0]    PAGE_LEN = LEN_W'(1) << PAGE_BITS;
    localparam logic [ENT_BITS-1:0] LAST_IDX = '1;
    localparam int                  N_WIN    = 4;
    localparam int                  N_PTR    = 2;

    walk_state_e         state_q;
    logic [ADDR_W-1:0]   p1_q, p2_q, sq_q, cb_q, cs_q;
    logic                cen_q;
    logic [LEN_W-1:0]    rem_q;
    logic [ADDR_W-1:0]   seg_addr_q;
    logic [LEN_W-1:0]    seg_len_q;
    logic [ADDR_W-1:0]   list_base_q;
    logic [ENT_BITS-1:0] idx_q;
    logic                listing_q;
    logic                flag_q;
    logic [15:0]         status_q;

    // Window decode for prp1, queue base, prp2 and the fetched entry
    logic [ADDR_W-1:0] win_addr [N_WIN];
    logic [N_WIN-1:0]  win_hit;
    assign win_addr[0] = p1_q;
    assign win_addr[1] = sq_q;
    assign win_addr[2] = p2_q;
    assign win_addr[3] = mem_rsp_data[ADDR_W-1:0];

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        prp_win_check #(.ADDR_W(ADDR_W)) u_win (
            .en   (cen_q),
            .base (cb_q),
            .size (cs_q),
            .addr (win_addr[w]),
            .hit  (win_hit[w])
        );
    end

    // Zero/alignment checks for prp2 and the fetched entry
    logic [ADDR_W-1:0] ptr_addr [N_PTR];
    logic [N_PTR-1:0]  ptr_zero, ptr_mis;
    assign ptr_addr[0] = p2_q;
    assign ptr_addr[1] = mem_rsp_data[ADDR_W-1:0];

    for (genvar p = 0; p < N_PTR; p++) begin : g_ptr
        prp_ptr_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
            .addr       (ptr_addr[p]),
            .is_zero    (ptr_zero[p]),
            .misaligned (ptr_mis[p])
        );
    end

    // First-segment length and the checks made before any segment is issued
    logic [LEN_W-1:0] room, first_len, rest_len;
    logic             p1_in_cmb;
    logic             chk_fail;
    logic [7:0]       chk_code;
    always_comb begin
        room      = PAGE_LEN - LEN_W'(p1_q[PAGE_BITS-1:0]);
        first_len = (rem_q < room) ? rem_q : room;
        rest_len  = rem_q - first_len;
        p1_in_cmb = win_hit[0] && (p1_q != '0);
        chk_fail  = 1'b1;
        chk_code  = SC_INVALID_FIELD;
        if (p1_q == '0) begin
            chk_code = SC_INVALID_FIELD;
        end else if (p1_in_cmb && !win_hit[1]) begin
            chk_code = SC_CMB_MISUSE;
        end else if ((rest_len != '0) && ptr_zero[0]) begin
            chk_code = SC_INVALID_FIELD;
        end else if ((rest_len != '0) && p1_in_cmb && !win_hit[2]) begin
            chk_code = SC_CMB_MISUSE;
        end else if ((rest_len != '0) && (rest_len <= PAGE_LEN) && ptr_mis[0]) begin
            chk_code = SC_INVALID_FIELD;
        end else begin
            chk_fail = 1'b0;
        end
    end

    // Classification of a returned list entry: error, chain hop or data page
    logic             rsp_fail, rsp_chain;
    logic [7:0]       rsp_code;
    logic [LEN_W-1:0] ent_len;
    logic             ent_bad;
    always_comb begin
        ent_bad   = ptr_zero[1] || ptr_mis[1];
        ent_len   = (rem_q < PAGE_LEN) ? rem_q : PAGE_LEN;
        rsp_fail  = 1'b0;
        rsp_chain = 1'b0;
        rsp_code  = SC_INVALID_FIELD;
        if (flag_q && !win_hit[3]) begin
            rsp_fail = 1'b1;
            rsp_code = SC_CMB_MISUSE;
        end else if (ent_bad) begin
            rsp_fail = 1'b1;
        end else if ((idx_q == LAST_IDX) && (rem_q > PAGE_LEN)) begin
            rsp_chain = 1'b1;
        end
    end

    logic [LEN_W-1:0] rem_after;
    assign rem_after = rem_q - seg_len_q;

    // Walk sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            p1_q        <= '0;
            p2_q        <= '0;
            sq_q        <= '0;
            cb_q        <= '0;
            cs_q        <= '0;
            cen_q       <= 1'b0;
            rem_q       <= '0;
            seg_addr_q  <= '0;
            seg_len_q   <= '0;
            list_base_q <= '0;
            idx_q       <= '0;
            listing_q   <= 1'b0;
            flag_q      <= 1'b0;
            status_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        p1_q    <= prp1;
                        p2_q    <= prp2;
                        sq_q    <= sq_base;
                        cen_q   <= cmb_en;
                        cb_q    <= cmb_base;
                        cs_q    <= cmb_size;
                        rem_q   <= xfer_len;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    flag_q    <= p1_in_cmb;
                    listing_q <= 1'b0;
                    if (chk_fail) begin
                        status_q <= err_status(chk_code);
                        state_q  <= ST_DONE;
                    end else begin
                        seg_addr_q <= p1_q;
                        seg_len_q  <= first_len;
                        state_q    <= ST_SEG;
                    end
                end
                ST_SEG: begin
                    if (seg_ready) begin
                        rem_q <= rem_after;
                        if (rem_after == '0) begin
                            status_q <= {8'h00, SC_SUCCESS};
                            state_q  <= ST_DONE;
                        end else if (listing_q) begin
                            idx_q   <= idx_q + ENT_BITS'(1);
                            state_q <= ST_REQ;
                        end else if (rem_after <= PAGE_LEN) begin
                            seg_addr_q <= p2_q;
                            seg_len_q  <= rem_after;
                        end else begin
                            listing_q   <= 1'b1;
                            list_base_q <= p2_q;
                            idx_q       <= '0;
                            state_q     <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state_q <= ST_RSP;
                end
                ST_RSP: begin
                    if (mem_rsp_valid) begin
                        if (rsp_fail) begin
                            status_q <= err_status(rsp_code);
                            state_q  <= ST_DONE;
                        end else if (rsp_chain) begin
                            list_base_q <= mem_rsp_data[ADDR_W-1:0];
                            idx_q       <= '0;
                            state_q     <= ST_REQ;
                        end else begin
                            seg_addr_q <= mem_rsp_data[ADDR_W-1:0];
                            seg_len_q  <= ent_len;
                            state_q    <= ST_SEG;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from state
    always_comb begin
        busy          = (state_q != ST_IDLE);
        seg_valid     = (state_q == ST_SEG);
        seg_addr      = seg_addr_q;
        seg_len       = seg_len_q;
        mem_req_valid = (state_q == ST_REQ);
        mem_req_addr  = list_base_q + ADDR_W'({idx_q, 3'b000});
        done          = (state_q == ST_DONE);
        status        = status_q;
        cmb_flag      = flag_q;
    end

    // R11: an unaccepted segment holds still
    p_seg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

    // R11: an unaccepted read request holds still
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R5: no segment is longer than a page or than what remains
    p_seg_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len <= PAGE_LEN) && (seg_len <= rem_q));

    // R7: segments taken from a list are page aligned
    p_list_seg_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && listing_q |-> (seg_addr[PAGE_BITS-1:0] == '0));

    // R9: a buffer-window transfer only issues segments inside the window
    p_cmb_seg_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && flag_q |-> (seg_addr >= cb_q) && ((seg_addr - cb_q) < cs_q));

    // R10: done lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: success is only reported once every byte has been issued
    p_ok_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && (status == 16'h0000) |-> (rem_q == '0));

endmodule

// File: tb/sim_prp_walker.sv
`timescale 1ns/1ps
// Bench for prp_walker: directed corner cases plus seeded random walks,
// compared against a requirement-level model of the segment stream.
module sim_prp_walker;

    localparam int PB   = 6;
    localparam int EB   = 2;
    localparam int AW   = 64;
    localparam int LW   = 32;
    localparam int PAGE = 1 << PB;
    localparam int ENTS = 1 << EB;
    localparam logic [15:0] ST_IF  = 16'h4002;
    localparam logic [15:0] ST_CMB = 16'h4012;

    logic          clk, rst_n, start;
    logic [AW-1:0] prp1, prp2, sq_base, cmb_base, cmb_size;
    logic [LW-1:0] xfer_len;
    logic          cmb_en;
    logic          busy, mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr;
    logic [63:0]   mem_rsp_data;
    logic          seg_valid, seg_ready, done, cmb_flag;
    logic [AW-1:0] seg_addr;
    logic [LW-1:0] seg_len;
    logic [15:0]   status;

    prp_walker #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BITS(PB), .ENT_BITS(EB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .prp1(prp1), .prp2(prp2),
        .xfer_len(xfer_len), .sq_base(sq_base), .cmb_en(cmb_en),
        .cmb_base(cmb_base), .cmb_size(cmb_size), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .done(done), .status(status),
        .cmb_flag(cmb_flag)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] bmem [512];

    // observed results
    longint unsigned g_addr [64];
    int              g_len  [64];
    int              g_n;
    bit              done_seen;
    logic [15:0]     g_status;
    logic            g_flag;

    // expected results
    longint unsigned e_addr [64];
    int              e_len  [64];
    int              e_n;
    logic [15:0]     e_status;
    bit              e_flag;
    bit              m_en;
    longint unsigned m_base, m_size;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit inw(input longint unsigned a);
        return m_en && (a >= m_base) && ((a - m_base) < m_size);
    endfunction

    function automatic void push(input longint unsigned a, input int l);
        if (e_n < 64) begin
            e_addr[e_n] = a;
            e_len[e_n]  = l;
        end
        e_n++;
    endfunction

    // Expected segment stream, status and flag from the requirements
    task automatic model(input longint unsigned p1, input longint unsigned p2,
                         input longint unsigned sq, input int len);
        int first, rem, idx, l;
        longint unsigned base, ent;
        e_n = 0;
        e_status = 16'h0000;
        e_flag = (p1 != 0) && inw(p1);
        if (p1 == 0) begin e_status = ST_IF; return; end
        if (e_flag && !inw(sq)) begin e_status = ST_CMB; return; end
        first = PAGE - int'(p1 % PAGE);
        if (len < first) first = len;
        rem = len - first;
        if (rem > 0) begin
            if (p2 == 0) begin e_status = ST_IF; return; end
            if (e_flag && !inw(p2)) begin e_status = ST_CMB; return; end
            if (rem <= PAGE && (p2 % PAGE) != 0) begin e_status = ST_IF; return; end
        end
        push(p1, first);
        if (rem == 0) return;
        if (rem <= PAGE) begin push(p2, rem); return; end
        base = p2;
        idx = 0;
        while (rem > 0) begin
            ent = bmem[int'(((base + 64'(8 * idx)) >> 3) & 511)];
            if (e_flag && !inw(ent)) begin e_status = ST_CMB; return; end
            if (idx == ENTS - 1 && rem > PAGE) begin
                if (ent == 0 || (ent % PAGE) != 0) begin e_status = ST_IF; return; end
                base = ent;
                idx = 0;
            end else begin
                if (ent == 0 || (ent % PAGE) != 0) begin e_status = ST_IF; return; end
                l = (rem < PAGE) ? rem : PAGE;
                push(ent, l);
                rem -= l;
                idx++;
            end
        end
    endtask

    // Ready drivers change just after the rising edge
    initial begin
        seg_ready = 1'b0;
        mem_req_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            seg_ready     = ($urandom % 4) != 0;
            mem_req_ready = ($urandom % 3) != 0;
        end
    end

    // Segment and done monitor, sampled on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (seg_valid === 1'b1 && seg_ready) begin
                if (g_n < 64) begin
                    g_addr[g_n] = seg_addr;
                    g_len[g_n]  = int'(seg_len);
                end
                g_n++;
            end
            if (done === 1'b1) begin
                done_seen = 1'b1;
                g_status  = status;
                g_flag    = cmb_flag;
            end
        end
    end

    // List memory responder with 1..3 cycle latency
    initial begin
        longint unsigned a;
        int cnt;
        cnt = 0;
        a = 0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_data  = bmem[int'((a >> 3) & 511)];
                    mem_rsp_valid = 1'b1;
                end
            end else if (mem_req_valid === 1'b1 && mem_req_ready) begin
                a = mem_req_addr;
                cnt = 1 + int'($urandom % 3);
            end
        end
    end

    task automatic run_walk(input string tag, input longint unsigned p1,
                            input longint unsigned p2, input longint unsigned sq,
                            input int len, input bit en,
                            input longint unsigned cb, input longint unsigned cs);
        int t;
        int bad_i;
        m_en = en; m_base = cb; m_size = cs;
        model(p1, p2, sq, len);
        @(negedge clk);
        g_n = 0;
        done_seen = 1'b0;
        prp1 = p1; prp2 = p2; sq_base = sq; xfer_len = LW'(len);
        cmb_en = en; cmb_base = cb; cmb_size = cs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done_seen && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(done_seen, tag, "done seen", 64'(done_seen), 1);
        chk(g_status == e_status, tag, "status", g_status, e_status);
        chk(g_flag == e_flag, "R8", "cmb_flag", 64'(g_flag), 64'(e_flag));
        chk(g_n == e_n, tag, "segment count", 64'(g_n), 64'(e_n));
        bad_i = -1;
        for (int i = 0; i < e_n && i < g_n && i < 64; i++)
            if (bad_i < 0 && (g_addr[i] != e_addr[i] || g_len[i] != e_len[i])) bad_i = i;
        if (bad_i >= 0)
            chk(1'b0, tag, "segment address/length", g_addr[bad_i] ^ 64'(g_len[bad_i]),
                e_addr[bad_i] ^ 64'(e_len[bad_i]));
        else
            chk(1'b1, tag, "segments", 0, 0);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: counts as a failed check
    initial begin
        #(20ns * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] saved;
        int w;
        longint unsigned p1, p2, sq, cs;
        int len;
        bit en;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 512; i++) bmem[i] = '0;
        // list pages at 1024 + 64*k: three data slots and a chain slot
        for (int k = 0; k < 16; k++) begin
            for (int s = 0; s < 3; s++)
                bmem[(1024 + 64 * k) / 8 + s] = 64'h10000 + 64'(64 * (1 + ($urandom % 255)));
            bmem[(1024 + 64 * k) / 8 + 3] = 64'(1024 + 64 * (k + 1));
        end
        rst_n = 1'b0; start = 1'b0;
        prp1 = '0; prp2 = '0; sq_base = '0; xfer_len = '0;
        cmb_en = 1'b0; cmb_base = '0; cmb_size = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !seg_valid && !mem_req_valid && !done, "R10", "reset outputs idle",
            {busy, seg_valid, mem_req_valid, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: single short segment, and first page then direct second page
        run_walk("R1", 64'h20028, 64'h0, 64'h500, 10, 0, 0, 0);
        run_walk("R1", 64'h20028, 64'h30000, 64'h500, 24 + 50, 0, 0, 0);
        // R2: zero first pointer
        run_walk("R2", 64'h0, 64'h30000, 64'h500, 100, 0, 0, 0);
        // R3: bytes remain and second pointer is zero
        run_walk("R3", 64'h20000, 64'h0, 64'h500, 200, 0, 0, 0);
        // R4: direct page exactly one page, and misaligned direct page
        run_walk("R4", 64'h20000, 64'h30000, 64'h500, 128, 0, 0, 0);
        run_walk("R4", 64'h20000, 64'h30008, 64'h500, 100, 0, 0, 0);
        // R5: one list page, partial last page
        run_walk("R5", 64'h20010, 64'd1024, 64'h500, 48 + 150, 0, 0, 0);
        // R6: several chained list pages
        run_walk("R6", 64'h20000, 64'd1024, 64'h500, 64 * 12 + 5, 0, 0, 0);
        // R6: exactly the slots of one page used as data (no chain needed)
        run_walk("R6", 64'h20000, 64'd1024, 64'h500, 64 * 5, 0, 0, 0);
        // R7: bad data entry after chaining, bad chain pointer
        saved = bmem[(1024 + 64) / 8 + 1];
        bmem[(1024 + 64) / 8 + 1] = 64'h10020;
        run_walk("R7", 64'h20000, 64'd1024, 64'h500, 64 * 10, 0, 0, 0);
        bmem[(1024 + 64) / 8 + 1] = saved;
        saved = bmem[1024 / 8 + 3];
        bmem[1024 / 8 + 3] = 64'h0;
        run_walk("R7", 64'h20000, 64'd1024, 64'h500, 64 * 10, 0, 0, 0);
        bmem[1024 / 8 + 3] = saved;
        // R8: window disabled, pointer at window end, pointer at window base
        run_walk("R8", 64'h20000, 64'h0, 64'h20000, 32, 0, 64'h20000, 64'h1000);
        run_walk("R8", 64'h21000, 64'h0, 64'h500, 32, 1, 64'h20000, 64'h1000);
        run_walk("R8", 64'h20000, 64'h0, 64'h20000, 32, 1, 64'h20000, 64'h1000);
        // R9: queue outside, prp2 outside, entry outside, all inside
        run_walk("R9", 64'h8000, 64'h9000, 64'h20000, 100, 1, 0, 64'h10000);
        run_walk("R9", 64'h8000, 64'h30000, 64'h500, 100, 1, 0, 64'h10000);
        run_walk("R9", 64'h8000, 64'd1024, 64'h500, 300, 1, 0, 64'h10000);
        run_walk("R9", 64'h8000, 64'd1024, 64'h500, 700, 1, 0, 64'h100000);

        // R5: seeded random walks with occasional faults
        for (int n = 0; n < 150; n++) begin
            len = 1 + int'($urandom % 1500);
            p1 = 64'h20000 + 64'($urandom % 4096);
            p2 = ($urandom % 8 == 0) ? 64'h0 : 64'(1024 + 64 * ($urandom % 4));
            if ($urandom % 8 == 0) p2 = p2 + 8;
            en = ($urandom % 3) == 0;
            cs = 64'(64'h10000 * (1 + ($urandom % 3)));
            sq = ($urandom % 2) ? 64'h500 : 64'h40000;
            w = -1;
            saved = '0;
            if ($urandom % 6 == 0) begin
                w = 1024 / 8 + int'($urandom % 64);
                saved = bmem[w];
                bmem[w] = ($urandom % 2) ? 64'h0 : 64'h10010;
            end
            run_walk("R5", p1, p2, sq, len, en, 0, cs);
            if (w >= 0) bmem[w] = saved;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule